// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper Controller

This block sequences the four power switches of one full-bridge motor winding so that the winding current stays near a target level. In the on phase it closes one diagonal pair of switches. The polarity bit selects which pair. When a synchronized current-sense comparator reports that the target has been reached, the block opens the bridge for a fixed off-time. During that time the current decays in one of two ways. In slow decay, both low-side switches recirculate the current. In mixed decay, the opposite diagonal is driven first for five sixteenths of the off-time, and slow decay covers the rest. When the off-time ends, the block returns to the on phase.

Every change of switch pattern passes through a dead interval with all four switches open, so the high-side and low-side switch of a leg never conduct together. At the start of each on phase the comparator is ignored for a blanking window. A disable input and a fault input open all switches at once; a restart always passes through a dead interval. A zero-level flag from the translator turns off synchronous recirculation, so the decay phases leave all switches open. All timings are parameters in clock cycles: OFF_CYC, BLANK_CYC and DEAD_CYC, with the fast portion FAST_CYC = OFF_CYC*5/16.

States: HALT (all open, held while disabled or faulted), DEAD (all open for DEAD_CYC cycles, then the stored destination), ON (drive diagonal), FAST (drive opposite diagonal), SLOW (both low sides). Transitions: reset enters DEAD with destination ON. HALT goes to DEAD when disable and fault are clear. DEAD goes to its destination. ON goes to DEAD with destination FAST or SLOW on an accepted trip, or to DEAD with destination ON on a polarity change. FAST goes to DEAD with destination SLOW when the fast portion ends. SLOW goes to DEAD with destination ON when the off-time ends. Any state goes to HALT on disable or fault.

Top module: `chop_ctrl`

## Requirements
- R1: During reset all four gate outputs are low. After reset is released they stay low for DEAD_CYC cycles, and then the on phase starts.
- R2: The gate vector is written {src_a, snk_a, src_b, snk_b}. In the on phase, polarity 0 drives 1001 (high side A and low side B) and polarity 1 drives 0110. The polarity and the decay mode are sampled when the on phase is entered.
- R3: A comparator trip is ignored during the first BLANK_CYC cycles of each on phase. If the trip is held high, the on phase lasts BLANK_CYC+1 cycles.
- R4: With slow decay (mode 0), an accepted trip gives DEAD_CYC all-open cycles, then 0101 for OFF_CYC-DEAD_CYC cycles, then DEAD_CYC all-open cycles, then the on phase.
- R5: With mixed decay (mode 1), an accepted trip gives DEAD_CYC open cycles, then the opposite diagonal (0110 for polarity 0, 1001 for polarity 1) for FAST_CYC-DEAD_CYC cycles, then DEAD_CYC open cycles, then 0101 for OFF_CYC-FAST_CYC-DEAD_CYC cycles, then DEAD_CYC open cycles. FAST_CYC is OFF_CYC*5/16.
- R6: The high-side and low-side switch of one leg are never on together. Two different non-zero gate patterns are always separated by at least DEAD_CYC all-open cycles.
- R7: While disable is high, all gates are low in the same cycle. After disable falls, the gates stay low for DEAD_CYC+1 cycles, and then the on phase resumes.
- R8: While fault is high, all gates are low in the same cycle. After fault clears, the gates stay low for DEAD_CYC+1 cycles, and then the on phase resumes.
- R9: While the zero-level flag is high, the decay phases (fast and slow) drive all four gates low.
- R10: If the polarity input differs from the sampled polarity during an on phase, the on phase ends at the next edge. DEAD_CYC open cycles follow, then a new on phase with the new polarity and a fresh blanking window.
- R11: A change of the decay-mode input during an on phase has no effect on the off-time that follows that phase. It applies from the next on phase onward.
- R12: If an accepted trip and a polarity change fall in the same cycle, the trip wins. The off-time runs with the old polarity, and the next on phase uses the new polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| trip_i | input | 1 | Synchronized current-sense comparator trip |
| mixed_i | input | 1 | Decay mode from translator: 1 mixed, 0 slow |
| pol_i | input | 1 | Winding current polarity from translator |
| zero_i | input | 1 | Zero-level code: disables synchronous recirculation |
| hold_off_i | input | 1 | Output disable, high opens all switches |
| fault_i | input | 1 | Fault present, high opens all switches |
| src_a_o | output | 1 | High-side switch, leg A |
| snk_a_o | output | 1 | Low-side switch, leg A |
| src_b_o | output | 1 | High-side switch, leg B |
| snk_b_o | output | 1 | Low-side switch, leg B |

## Verification
Two of the block's functions compete for the same cycle. A comparator trip can land on the first unblanked on cycle in the same cycle as a polarity change from the translator, and both would end the on phase. The bench provokes this by flipping the polarity exactly on on-phase index BLANK_CYC while the trip is held. It then judges the outcome from the run lengths and patterns that follow. It expects a fast-decay pattern belonging to the old polarity, the full off-time sequence, and then an on phase with the new diagonal. Random stimulus follows and checks shoot-through, dead spacing and disable/fault blanking in every cycle.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        ST_HALT = 3'd0,
        ST_DEAD = 3'd1,
        ST_ON   = 3'd2,
        ST_FAST = 3'd3,
        ST_SLOW = 3'd4
    } chop_state_e;

    typedef struct packed {
        logic src_a;
        logic snk_a;
        logic src_b;
        logic snk_b;
    } gate_t;

endpackage

// File: rtl/chop_phase_cnt.sv
module chop_phase_cnt #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    // Cycles spent in the current state; saturates, cleared on each state change.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (cnt_o != '1) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/chop_off_timer.sv
module chop_off_timer #(
    parameter int OFF_CYC  = 1500,
    parameter int FAST_CYC = 468
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic run_i,
    output logic fast_done_o,
    output logic off_done_o
);
    localparam int W = $clog2(OFF_CYC + 1);
    localparam logic [W-1:0] OFF_LAST  = W'(OFF_CYC - 1);
    localparam logic [W-1:0] FAST_LAST = W'(FAST_CYC - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= '0;
        end else if (run_i && cnt_q != OFF_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fast_done_o = (cnt_q == FAST_LAST);
    assign off_done_o  = (cnt_q == OFF_LAST);

    // R4: the off-time counter never runs past its last cycle
    assert_off_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= OFF_LAST);
endmodule

// File: rtl/chop_gate_map.sv
module chop_gate_map
    import chop_pkg::*;
(
    input  chop_state_e state_i,
    input  logic        pol_i,
    input  logic        zero_i,
    input  logic        kill_i,
    output gate_t       gate_o
);
    always_comb begin
        gate_o = '0;
        unique case (state_i)
            ST_ON: begin
                if (pol_i) begin
                    gate_o.src_b = 1'b1;
                    gate_o.snk_a = 1'b1;
                end else begin
                    gate_o.src_a = 1'b1;
                    gate_o.snk_b = 1'b1;
                end
            end
            ST_FAST: begin
                if (!zero_i) begin
                    if (pol_i) begin
                        gate_o.src_a = 1'b1;
                        gate_o.snk_b = 1'b1;
                    end else begin
                        gate_o.src_b = 1'b1;
                        gate_o.snk_a = 1'b1;
                    end
                end
            end
            ST_SLOW: begin
                if (!zero_i) begin
                    gate_o.snk_a = 1'b1;
                    gate_o.snk_b = 1'b1;
                end
            end
            ST_HALT, ST_DEAD: gate_o = '0;
            default:          gate_o = '0;
        endcase
        if (kill_i) begin
            gate_o = '0;
        end
    end
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int OFF_CYC   = 1500,
    parameter int BLANK_CYC = 50,
    parameter int DEAD_CYC  = 24
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trip_i,
    input  logic mixed_i,
    input  logic pol_i,
    input  logic zero_i,
    input  logic hold_off_i,
    input  logic fault_i,
    output logic src_a_o,
    output logic snk_a_o,
    output logic src_b_o,
    output logic snk_b_o
);
    localparam int FAST_CYC = OFF_CYC * 5 / 16;
    localparam int PH_MAX   = (BLANK_CYC > DEAD_CYC) ? BLANK_CYC : DEAD_CYC;
    localparam int PH_W     = $clog2(PH_MAX + 1) + 1;
    localparam logic [PH_W-1:0] DEAD_LAST = PH_W'(DEAD_CYC - 1);
    localparam logic [PH_W-1:0] BLANK_END = PH_W'(BLANK_CYC);

    chop_state_e     state_q, state_d;
    chop_state_e     dest_q, dest_d;
    logic            pol_q, mix_q;
    logic            take_cfg, off_start, off_run;
    logic            fast_done, off_done;
    logic            kill;
    logic [PH_W-1:0] ph_cnt;
    gate_t           gate;

    assign kill = hold_off_i | fault_i;

    chop_phase_cnt #(.W(PH_W)) u_phase (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (state_d != state_q),
        .cnt_o  (ph_cnt)
    );

    assign off_run = (state_q == ST_FAST) || (state_q == ST_SLOW) ||
                     ((state_q == ST_DEAD) && (dest_q != ST_ON));

    chop_off_timer #(.OFF_CYC(OFF_CYC), .FAST_CYC(FAST_CYC)) u_off (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (off_start),
        .run_i       (off_run),
        .fast_done_o (fast_done),
        .off_done_o  (off_done)
    );

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        dest_d    = dest_q;
        off_start = 1'b0;
        take_cfg  = 1'b0;
        if (kill) begin
            state_d = ST_HALT;
        end else begin
            unique case (state_q)
                ST_HALT: begin
                    state_d = ST_DEAD;
                    dest_d  = ST_ON;
                end
                ST_DEAD: begin
                    if (ph_cnt == DEAD_LAST) begin
                        state_d  = dest_q;
                        take_cfg = (dest_q == ST_ON);
                    end
                end
                ST_ON: begin
                    if (trip_i && ph_cnt >= BLANK_END) begin
                        state_d   = ST_DEAD;
                        dest_d    = mix_q ? ST_FAST : ST_SLOW;
                        off_start = 1'b1;
                    end else if (pol_i != pol_q) begin
                        state_d = ST_DEAD;
                        dest_d  = ST_ON;
                    end
                end
                ST_FAST: begin
                    if (fast_done) begin
                        state_d = ST_DEAD;
                        dest_d  = ST_SLOW;
                    end
                end
                ST_SLOW: begin
                    if (off_done) begin
                        state_d = ST_DEAD;
                        dest_d  = ST_ON;
                    end
                end
                default: state_d = ST_HALT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_DEAD;
            dest_q  <= ST_ON;
            pol_q   <= 1'b0;
            mix_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            dest_q  <= dest_d;
            if (take_cfg) begin
                pol_q <= pol_i;
                mix_q <= mixed_i;
            end
        end
    end

    // Output decode
    chop_gate_map u_map (
        .state_i (state_q),
        .pol_i   (pol_q),
        .zero_i  (zero_i),
        .kill_i  (kill),
        .gate_o  (gate)
    );

    always_comb begin
        src_a_o = gate.src_a;
        snk_a_o = gate.snk_a;
        src_b_o = gate.src_b;
        snk_b_o = gate.snk_b;
    end

    // R6: no leg conducts through both of its switches
    assert_no_shoot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(src_a_o && snk_a_o) && !(src_b_o && snk_b_o));

    // R6: a dead interval is not cut short unless the bridge is being shut down
    assert_dead_min_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_DEAD && ph_cnt < DEAD_LAST && !kill) |=> state_q == ST_DEAD);

    // R3: the on phase survives its blanking window when polarity is steady
    assert_blank_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ON && ph_cnt < BLANK_END && pol_i == pol_q && !kill)
        |=> state_q == ST_ON);

    // R7: disable forces the halt state
    assert_halt_disable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_off_i |=> state_q == ST_HALT);

    // R8: fault forces the halt state and the gates are open
    assert_halt_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_i |-> !(src_a_o || snk_a_o || src_b_o || snk_b_o));

    // R9: zero level leaves the decay phases without drive
    assert_zero_open_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (zero_i && (state_q == ST_FAST || state_q == ST_SLOW))
        |-> !(src_a_o || snk_a_o || src_b_o || snk_b_o));
endmodule

// File: tb/test_chop_ctrl.sv
module test_chop_ctrl;
    localparam int OFF  = 64;
    localparam int BLNK = 6;
    localparam int DT   = 3;
    localparam int FST  = OFF * 5 / 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trip = 1'b0, mixed = 1'b0, pol = 1'b0, zero = 1'b0, dis = 1'b0, flt = 1'b0;
    logic src_a, snk_a, src_b, snk_b;
    logic [3:0] g;

    int n_chk = 0;
    int n_fail = 0;
    int rp[16];
    int rl[16];

    always #10 clk = ~clk;

    assign g = {src_a, snk_a, src_b, snk_b};

    chop_ctrl #(.OFF_CYC(OFF), .BLANK_CYC(BLNK), .DEAD_CYC(DT)) i_chop_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .trip_i(trip), .mixed_i(mixed), .pol_i(pol),
        .zero_i(zero), .hold_off_i(dis), .fault_i(flt),
        .src_a_o(src_a), .snk_a_o(snk_a), .src_b_o(src_b), .snk_b_o(snk_b)
    );

    function automatic int exp_on(input logic p);
        return p ? 4'b0110 : 4'b1001;
    endfunction

    function automatic int exp_fast(input logic p);
        return p ? 4'b1001 : 4'b0110;
    endfunction

    function automatic bit legal(input logic [3:0] v);
        return (v == 4'b0000) || (v == 4'b1001) || (v == 4'b0110) || (v == 4'b0101);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic capture(input int n);
        int cur = g;
        int len = 1;
        int k = 0;
        int guard = 0;
        while (k < n && guard < 2000) begin
            tick();
            guard++;
            if (g == cur) len++;
            else begin
                rp[k] = cur; rl[k] = len; k++;
                cur = g; len = 1;
            end
        end
        if (guard >= 2000) chk("capture", "timeout", 1, 0);
    endtask

    task automatic wait_on(input int p);
        int prev;
        int guard = 0;
        prev = g;
        tick();
        while (!(g == p && prev == 0) && guard < 2000) begin
            prev = g;
            tick();
            guard++;
        end
        if (guard >= 2000) chk("wait", "on phase timeout", 1, 0);
    endtask

    task automatic run_is(input string req, input int i, input int p, input int len);
        chk(req, $sformatf("run %0d pattern", i), rp[i], p);
        chk(req, $sformatf("run %0d length", i), rl[i], len);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        int k;
        int z;
        int last_nz;
        int zrun;
        logic [3:0] prev_g;

        // R1: reset state
        mixed = 1'b1;
        repeat (3) tick();
        chk("R1", "gates in reset", g, 0);
        rst_n = 1'b1;
        z = 0;
        while (g == 0 && z < 100) begin z++; tick(); end
        chk("R1", "open cycles after reset", z, DT);
        chk("R2", "on pattern polarity 0", g, exp_on(1'b0));

        // R3, R5: held trip, mixed decay
        trip = 1'b1;
        capture(6);
        run_is("R3", 0, exp_on(1'b0), BLNK + 1);
        run_is("R5", 1, 0, DT);
        run_is("R5", 2, exp_fast(1'b0), FST - DT);
        run_is("R5", 3, 0, DT);
        run_is("R5", 4, 4'b0101, OFF - FST - DT);
        run_is("R5", 5, 0, DT);

        // R4: slow decay
        mixed = 1'b0;
        capture(6);
        capture(4);
        run_is("R4", 0, exp_on(1'b0), BLNK + 1);
        run_is("R4", 1, 0, DT);
        run_is("R4", 2, 4'b0101, OFF - DT);
        run_is("R4", 3, 0, DT);

        // R11: mode change inside an on phase waits for the next one
        mixed = 1'b1;
        capture(7);
        run_is("R11", 2, 4'b0101, OFF - DT);
        run_is("R11", 6, exp_fast(1'b0), FST - DT);

        // R9: zero level, slow decay latched
        mixed = 1'b0;
        zero = 1'b1;
        wait_on(exp_on(1'b0));
        capture(2);
        run_is("R9", 0, exp_on(1'b0), BLNK + 1);
        run_is("R9", 1, 0, OFF + DT);
        zero = 1'b0;

        // R3: short pulses inside blanking ignored, accepted after
        trip = 1'b0;
        k = 0;
        while (g == exp_on(1'b0) && k < 100) begin
            if (k == 5) trip = 1'b1;
            if (k == 6) trip = 1'b0;
            if (k == 10) trip = 1'b1;
            tick();
            k++;
        end
        trip = 1'b0;
        chk("R3", "on length with trip at index 10", k, 11);
        chk("R6", "open after on phase", g, 0);

        // R10: polarity change during on phase
        wait_on(exp_on(1'b0));
        k = 0;
        while (g == exp_on(1'b0) && k < 100) begin
            if (k == 2) pol = 1'b1;
            tick();
            k++;
        end
        chk("R10", "on length before polarity swap", k, 3);
        z = 0;
        while (g == 0 && z < 100) begin z++; tick(); end
        chk("R10", "dead before new polarity", z, DT);
        chk("R2", "on pattern polarity 1", g, exp_on(1'b1));
        trip = 1'b1;
        k = 0;
        while (g == exp_on(1'b1) && k < 100) begin tick(); k++; end
        chk("R10", "fresh blanking after swap", k, BLNK + 1);

        // R12: trip and polarity change in the same cycle
        mixed = 1'b1;
        wait_on(exp_on(1'b1));
        k = 0;
        while (g == exp_on(1'b1) && k < 100) begin
            if (k == BLNK) pol = 1'b0;
            tick();
            k++;
        end
        chk("R12", "on length at collision", k, BLNK + 1);
        capture(5);
        run_is("R12", 0, 0, DT);
        run_is("R12", 1, exp_fast(1'b1), FST - DT);
        run_is("R12", 3, 4'b0101, OFF - FST - DT);
        chk("R12", "next on uses new polarity", g, exp_on(1'b0));

        // R7: disable
        repeat (15) tick();
        dis = 1'b1;
        #1;
        chk("R7", "gates same cycle as disable", g, 0);
        repeat (4) begin tick(); chk("R7", "gates while disabled", g, 0); end
        dis = 1'b0;
        z = 0;
        while (g == 0 && z < 100) begin z++; tick(); end
        chk("R7", "open cycles after disable", z, DT + 1);
        chk("R7", "resume on pattern", g, exp_on(1'b0));

        // R8: fault
        repeat (40) tick();
        flt = 1'b1;
        #1;
        chk("R8", "gates same cycle as fault", g, 0);
        repeat (4) begin tick(); chk("R8", "gates while faulted", g, 0); end
        flt = 1'b0;
        z = 0;
        while (g == 0 && z < 100) begin z++; tick(); end
        chk("R8", "open cycles after fault", z, DT + 1);
        chk("R8", "resume on pattern", g, exp_on(1'b0));

        // Random phase: R6, R7, R8 per cycle
        void'($urandom(32'd7411));
        last_nz = g;
        zrun = 0;
        prev_g = g;
        for (int i = 0; i < 4000; i++) begin
            trip  = ($urandom % 2) == 0;
            if (($urandom % 50) == 0) pol = ~pol;
            if (($urandom % 10) == 0) mixed = ~mixed;
            zero  = ($urandom % 20) == 0;
            dis   = ($urandom % 100) == 0;
            flt   = ($urandom % 100) == 0;
            tick();
            chk("R6", "legal pattern", legal(g), 1);
            chk("R6", "no leg shoot-through", (src_a & snk_a) | (src_b & snk_b), 0);
            if (dis) chk("R7", "random disable opens gates", g, 0);
            if (flt) chk("R8", "random fault opens gates", g, 0);
            if (g != 0) begin
                if (prev_g != 0 && prev_g != g)
                    chk("R6", "direct pattern switch", prev_g, g);
                else if (prev_g == 0 && g != last_nz && zrun < DT)
                    chk("R6", "dead interval length", zrun, DT);
                last_nz = g;
                zrun = 0;
            end else begin
                zrun++;
            end
            prev_g = g;
        end

        summary();
        $finish;
    end
endmodule